// File: doc/BRIEF.md
# Encoded Reference Clock Divider

This block takes a reference clock of 2 to 20 MHz and divides it down to the phase-comparison rate of a frequency synthesiser. That rate must not exceed 4 MHz. The ratio comes from a 5-bit code. The two upper code bits pick a base factor of 1, 5, 6 or 7. The three lower bits pick a power of two that scales the base. This gives 29 usable ratios between 2 and 448. Three codes are reserved.

The output is a pulse one reference clock wide, once per divided period. Because of this, odd ratios need no balanced duty cycle. A new code is first captured as a pending ratio. The running count only takes it at the next terminal count, so the comparison pulse train never gets a short or torn period. A reserved code raises a flag and leaves the last legal ratio in place.

Top module: `refclk_ratio_divider`

## Requirements
- R1: With ratio_code[4:3] = 00, lower field n = ratio_code[2:0] (0..7) gives a period of 2^(n+1) reference cycles (2 up to 256).
- R2: With ratio_code[4:3] = 01 and n in 1..7, the period is 5 x 2^(n-1) cycles (5 up to 320).
- R3: With ratio_code[4:3] = 10 and n in 1..7, the period is 6 x 2^(n-1) cycles (6 up to 384).
- R4: With ratio_code[4:3] = 11 and n in 1..7, the period is 7 x 2^(n-1) cycles (7 up to 448).
- R5: The codes 01000, 10000 and 11000 are reserved. After each rising edge at which one of them is present, code_bad is 1. After an edge with a legal code, code_bad is 0.
- R6: While a reserved code is applied, the period stays at the last legal ratio.
- R7: fcomp is high for exactly one reference cycle per period and low in the other cycles.
- R8: A code change never cuts the period in progress short. That period ends at the old ratio, and the new ratio starts at the following period.
- R9: Synchronous active-low reset sets the ratio to 2. While reset is applied, fcomp and code_bad are 0. fcomp goes high right after the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_code | input | 5 | Encoded division ratio select |
| fcomp | output | 1 | One-cycle comparison pulse per divided period |
| code_bad | output | 1 | Registered flag for a reserved ratio code |

## Verification
The assertions take two things for granted:
- ratio_code is synchronous to clk_ref and meets setup at each edge.
- rst_n is held low for at least one edge before use, so the pending and running ratios start from a known legal value.

On that basis the pending ratio is always a legal ratio, and the count never reaches the running ratio. The stimulus changes the code only between edges and one step after a sampled edge. Every period is measured only after two pulses have passed since the last change, except in the scenario that deliberately changes the code in the middle of a long period.

// File: rtl/refdiv_pkg.sv
// Package: shared widths and the code-to-ratio mapping for the reference divider.
// Assumes the code layout: upper two bits pick base 1/5/6/7, lower three bits the power of two.
package refdiv_pkg;
    localparam int CODE_W    = 5;
    localparam int SEL_W     = 3;
    localparam int RATIO_W   = 9;
    localparam int RST_RATIO = 2;
    localparam int MAX_RATIO = 448;
    localparam int MIN_RATIO = 2;
endpackage

// File: rtl/refdiv_decode.sv
// Module: refdiv_decode
// Turns the 5-bit ratio code into a binary ratio and a reserved-code indication.
// The module is purely combinational. The ratio output is meaningless when bad_o is set.
module refdiv_decode
    import refdiv_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               bad_o
);
    localparam int GROUPS = 1 << (CODE_W - SEL_W);

    logic [RATIO_W-1:0] base_tab [GROUPS];
    logic [SEL_W-1:0]   grp;
    logic [SEL_W-1:0]   sel;
    logic [3:0]         shamt;

    // Base factor for each group: group 0 is 1, groups 1..3 are 5..7.
    for (genvar g = 0; g < GROUPS; g++) begin : g_base
        assign base_tab[g] = (g == 0) ? RATIO_W'(1) : RATIO_W'(g + 4);
    end

    assign grp = SEL_W'(code_i[CODE_W-1:SEL_W]);
    assign sel = code_i[SEL_W-1:0];

    // Shift amount: group 0 starts at 2^1, the others at 2^0 for a field value of 1.
    always_comb begin
        if (grp == '0) shamt = {1'b0, sel} + 4'd1;
        else           shamt = {1'b0, sel} - 4'd1;
    end

    // A field value of zero is reserved in every group except group 0.
    assign bad_o   = (grp != '0) && (sel == '0);
    assign ratio_o = base_tab[grp[CODE_W-SEL_W-1:0]] << shamt;
endmodule

// File: rtl/refdiv_select.sv
// Module: refdiv_select
// Holds the most recent legal ratio as the pending ratio and registers the reserved-code flag.
// Assumes the code is synchronous to clk. A reserved code leaves the pending ratio untouched.
module refdiv_select
    import refdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               bad_i,
    output logic [RATIO_W-1:0] pending_o,
    output logic               bad_flag_o
);
    // Capture each legal ratio; hold across reserved codes.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending_o <= RATIO_W'(RST_RATIO);
        else if (!bad_i) pending_o <= ratio_i;
    end

    // Register the reserved-code indication for the output flag.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_flag_o <= 1'b0;
        else        bad_flag_o <= bad_i;
    end

    AST_HOLD_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        bad_i |=> $stable(pending_o)); // R6
    AST_PENDING_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o >= RATIO_W'(MIN_RATIO)) && (pending_o <= RATIO_W'(MAX_RATIO))); // R1
    AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_i |=> bad_flag_o); // R5
endmodule

// File: rtl/refdiv_counter.sv
// Module: refdiv_counter
// Down-counter that produces one pulse per period. It loads the pending ratio only at the terminal count.
// Assumes the pending ratio is at least 2, so pulses are always separated by at least one low cycle.
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] pending_i,
    output logic               pulse_o
);
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] active_q;
    logic               tc;

    assign tc      = (cnt_q == '0);
    assign pulse_o = tc;

    // Count down; at terminal count reload from the pending ratio and adopt it as active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= RATIO_W'(RST_RATIO - 1);
            active_q <= RATIO_W'(RST_RATIO);
        end else if (tc) begin
            cnt_q    <= pending_i - RATIO_W'(1);
            active_q <= pending_i;
        end else begin
            cnt_q    <= cnt_q - RATIO_W'(1);
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc); // R7
    AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < active_q); // R7
    AST_SWITCH_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> $past(tc)); // R8
endmodule

// File: rtl/refclk_ratio_divider.sv
// Module: refclk_ratio_divider
// Top level: decodes the ratio code, stages legal ratios, and divides the reference clock.
// Assumes ratio_code is synchronous to clk_ref, and that rst_n is synchronous and active low.
module refclk_ratio_divider
    import refdiv_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              fcomp,
    output logic              code_bad
);
    logic [RATIO_W-1:0] dec_ratio;
    logic               dec_bad;
    logic [RATIO_W-1:0] pending;

    refdiv_decode u_decode (
        .code_i  (ratio_code),
        .ratio_o (dec_ratio),
        .bad_o   (dec_bad)
    );

    refdiv_select u_select (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .ratio_i    (dec_ratio),
        .bad_i      (dec_bad),
        .pending_o  (pending),
        .bad_flag_o (code_bad)
    );

    refdiv_counter u_counter (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .pending_i (pending),
        .pulse_o   (fcomp)
    );

    AST_FLAG_CLEARS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !dec_bad |=> !code_bad); // R5
endmodule

// File: tb/sim_refclk_ratio_divider.sv
`timescale 1ns/1ps
module sim_refclk_ratio_divider;
    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [4:0] ratio_code = 5'b00000;
    logic       fcomp;
    logic       code_bad;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #2.5 clk_ref = ~clk_ref;

    refclk_ratio_divider u0 (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .fcomp      (fcomp),
        .code_bad   (code_bad)
    );

    // Expected period from the requirement formulas.
    function automatic int exp_ratio(input logic [4:0] c);
        int n;
        n = int'(c[2:0]);
        case (c[4:3])
            2'b00:   return 1 << (n + 1);
            2'b01:   return 5 * (1 << (n - 1));
            2'b10:   return 6 * (1 << (n - 1));
            default: return 7 * (1 << (n - 1));
        endcase
    endfunction

    function automatic bit is_reserved(input logic [4:0] c);
        return (c[4:3] != 2'b00) && (c[2:0] == 3'b000);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk_ref);
        #1;
    endtask

    task automatic wait_pulse();
        int guard;
        guard = 0;
        do begin
            tick();
            guard++;
        end while (!fcomp && guard < 1000);
    endtask

    // Cycles from the current pulse to the next one.
    task automatic measure(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!fcomp && n < 1000);
    endtask

    task automatic settle();
        wait_pulse();
        wait_pulse();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check(fcomp == 1'b0, "R9 fcomp in reset", int'(fcomp), 0);
        check(code_bad == 1'b0, "R9 code_bad in reset", int'(code_bad), 0);
        rst_n = 1'b1;
        tick();
        check(fcomp == 1'b1, "R9 first pulse after release", int'(fcomp), 1);
        begin
            int p;
            measure(p);
            check(p == 2, "R9 reset ratio", p, 2);
        end
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 32; c++) begin
            logic [4:0] code;
            int p;
            code = 5'(c);
            if (is_reserved(code)) continue;
            ratio_code = code;
            settle();
            measure(p);
            case (code[4:3])
                2'b00:   check(p == exp_ratio(code), "R1 period", p, exp_ratio(code));
                2'b01:   check(p == exp_ratio(code), "R2 period", p, exp_ratio(code));
                2'b10:   check(p == exp_ratio(code), "R3 period", p, exp_ratio(code));
                default: check(p == exp_ratio(code), "R4 period", p, exp_ratio(code));
            endcase
            tick();
            check(fcomp == 1'b0, "R7 pulse one cycle wide", int'(fcomp), 0);
            check(code_bad == 1'b0, "R5 flag low on legal code", int'(code_bad), 0);
        end
    endtask

    task automatic t_reserved();
        logic [4:0] bad_codes [3];
        bad_codes[0] = 5'b01000;
        bad_codes[1] = 5'b10000;
        bad_codes[2] = 5'b11000;
        for (int i = 0; i < 3; i++) begin
            int p;
            ratio_code = 5'b01001;
            settle();
            ratio_code = bad_codes[i];
            tick();
            check(code_bad == 1'b1, "R5 flag on reserved code", int'(code_bad), 1);
            settle();
            measure(p);
            check(p == 5, "R6 ratio held on reserved code", p, 5);
            check(code_bad == 1'b1, "R5 flag held", int'(code_bad), 1);
            ratio_code = 5'b00000;
            tick();
            check(code_bad == 1'b0, "R5 flag cleared", int'(code_bad), 0);
        end
    endtask

    task automatic t_midchange();
        int p;
        ratio_code = 5'b11111;
        settle();
        repeat (10) tick();
        ratio_code = 5'b00000;
        measure(p);
        check(p == 438, "R8 current period completes at old ratio", p, 438);
        measure(p);
        check(p == 2, "R8 new ratio from next period", p, 2);
        ratio_code = 5'b01111;
        settle();
        repeat (3) tick();
        ratio_code = 5'b10001;
        measure(p);
        check(p == 317, "R8 long period completes", p, 317);
        measure(p);
        check(p == 6, "R8 switch to 6", p, 6);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_reserved();
        t_midchange();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule